// File: doc/BRIEF.md
# Pixel Matrix Row-Pair Readout Sequencer

This block produces the row-side control timing for an active pixel sensor matrix. In this matrix the transistor gates and the clear contacts run along rows and the drains run along columns. The block steps through the matrix one row pair at a time, and two rows are read together. For each pair it runs five phases in a fixed order. First the gate lines turn on and settle. A first sample strobe then captures signal plus pedestal. The clear lines pulse. A second sample strobe captures the pedestal alone. Finally the gates switch off.

The block drives three things: the row gate enables, the row clear enables, and two sample strobes for the column readout electronics. A small table holds the length in clocks of each of the five phases and can be written at any time. A start pulse begins a frame at pair 0. When the last pair ends, a one-cycle frame-done pulse is raised. The sequencer then either waits idle or begins the next frame at once, depending on the continuous-mode input. A stop pulse ends the run cleanly after the pair that is in progress.

Top module: `row_readout_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `busy`, every `gate_row` bit, every `clear_row` bit, `sample1`, `sample2` and `frame_done` are all 0.
- R2: A start pulse accepted while idle makes pair 0 active in the next cycle. Each pair then passes through its phases in this order: gate-on for T0 cycles, sample 1 for T1, clear for T2, sample 2 for T3 and gate-off for T4. Tn is timing-table entry n.
- R3: Pair p drives exactly the gate rows ROWS_PER_STEP*p up to ROWS_PER_STEP*p+ROWS_PER_STEP-1, and drives them in the gate-on, sample 1, clear and sample 2 phases. No other gate row is driven. `clear_row` drives those same rows only in the clear phase.
- R4: The clear enable never coincides with `sample1` or `sample2`. Each sample strobe is high only while the active pair's gates are on.
- R5: Writing with `cfg_we` high and index 0 to 4 on `cfg_idx` sets the matching table entry to `cfg_val`. A written value of 0 is stored as 1. Indices 5 to 7 have no effect. After reset every entry holds 1.
- R6: Pairs are visited in ascending order from 0 to NUM_PAIRS-1, and `row_pair` reports the active pair. `frame_done` is high for exactly one cycle: the final cycle of the last pair's gate-off phase.
- R7: At the end of a frame, with `continuous` high, pair 0 starts in the very next cycle with no idle gap. With `continuous` low, the sequencer is idle in the next cycle.
- R8: A stop pulse while busy lets the current pair finish its gate-off phase, and the sequencer is idle in the cycle after that.
- R9: A start pulse while busy has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a frame at pair 0 (accepted only while idle) |
| stop | input | 1 | Halt after the current row pair |
| continuous | input | 1 | 1: wrap to pair 0 after the last pair; 0: go idle |
| cfg_we | input | 1 | Timing table write enable |
| cfg_idx | input | 3 | Table index: 0 gate-on, 1 sample 1, 2 clear, 3 sample 2, 4 gate-off |
| cfg_val | input | DUR_W | Phase length in clocks (0 stored as 1) |
| gate_row | output | NUM_ROWS | Per-row gate enable |
| clear_row | output | NUM_ROWS | Per-row clear enable |
| sample1 | output | 1 | First sample strobe (signal plus pedestal) |
| sample2 | output | 1 | Second sample strobe (pedestal) |
| row_pair | output | $clog2(NUM_ROWS/ROWS_PER_STEP) | Index of the active row pair |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Sequencer running |

## Verification
Some properties are checked by assertions on every cycle:
- the clear enable and the sample strobes never overlap;
- exactly one row pair's worth of gates is on whenever any gate is on;
- the clear rows match the gate rows;
- a sample strobe appears only while gates are on;
- phases and pairs advance only in their legal order;
- the sequencer goes idle after a non-continuous frame end or a stop.

Other behaviours can only be shown by the bench's scenarios, which compare every cycle of whole frames against a model built from the programmed durations. These are:
- the exact phase lengths taken from the table, including the clamping of zero;
- the placement of `frame_done` in time;
- the seamless wrap in continuous mode;
- the number of cycles before a stop takes effect;
- the immunity to stray start pulses and to unused table indices.

// File: rtl/rrs_pkg.sv
// Shared types for the row readout sequencer.
// Phase encoding is also the timing table index, so the order matters.
package rrs_pkg;

    typedef enum logic [2:0] {
        PH_GATE_ON  = 3'd0,
        PH_SAMPLE1  = 3'd1,
        PH_CLEAR    = 3'd2,
        PH_SAMPLE2  = 3'd3,
        PH_GATE_OFF = 3'd4
    } phase_t;

    localparam int unsigned NUM_PHASES = 5;

endpackage

// File: rtl/rrs_timing_table.sv
// Timing table: one duration entry per phase, in clocks.
// Assumes: index values at or above NUM_PHASES are ignored; zero is stored as 1
// so that every phase lasts at least one clock. Reset loads 1 into each entry.
module rrs_timing_table
    import rrs_pkg::*;
#(
    parameter int unsigned DUR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_idx,
    input  logic [DUR_W-1:0] cfg_val,
    input  phase_t           rd_phase,
    output logic [DUR_W-1:0] rd_dur
);

    localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

    logic [DUR_W-1:0] dur_q [NUM_PHASES];
    logic [DUR_W-1:0] wr_val;

    // Clamp the incoming value to the one-clock minimum
    always_comb wr_val = (cfg_val == '0) ? DUR_ONE : cfg_val;

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_entry
        // Hold or update one table entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                dur_q[g] <= DUR_ONE;
            else if (cfg_we && (cfg_idx == 3'(g)))
                dur_q[g] <= wr_val;
        end
    end

    // Read the entry for the phase now running
    always_comb begin
        case (rd_phase)
            PH_GATE_ON:  rd_dur = dur_q[0];
            PH_SAMPLE1:  rd_dur = dur_q[1];
            PH_CLEAR:    rd_dur = dur_q[2];
            PH_SAMPLE2:  rd_dur = dur_q[3];
            PH_GATE_OFF: rd_dur = dur_q[4];
            default:     rd_dur = DUR_ONE;
        endcase
    end

endmodule

// File: rtl/rrs_phase_ctrl.sv
// Phase controller: walks the five phases for each row pair, counts clocks
// per phase against the timing table, and steps through the row pairs.
// Assumes: rd_dur is never zero; stop is latched while busy and acts at the
// end of the current pair's gate-off phase.
module rrs_phase_ctrl
    import rrs_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 64,
    parameter int unsigned DUR_W     = 4,
    localparam int unsigned PAIR_W   = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              continuous,
    input  logic [DUR_W-1:0]  rd_dur,
    output logic              busy,
    output phase_t            phase,
    output logic [PAIR_W-1:0] pair,
    output logic              frame_done
);

    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_PAIRS - 1);

    logic              busy_q;
    phase_t            phase_q;
    logic [PAIR_W-1:0] pair_q;
    logic [DUR_W-1:0]  cnt_q;
    logic              stop_q;
    logic              phase_end;
    logic              pair_end;
    logic              frame_end;
    logic              halt;

    // End-of-phase, end-of-pair and end-of-frame decisions
    always_comb begin
        phase_end = busy_q && (cnt_q >= (rd_dur - DUR_W'(1)));
        pair_end  = phase_end && (phase_q == PH_GATE_OFF);
        frame_end = pair_end && (pair_q == LAST_PAIR);
        halt      = pair_end && (stop || stop_q || (frame_end && !continuous));
    end

    // Sequencer state: running flag, phase, pair, phase clock count, stop latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= PH_GATE_ON;
            pair_q  <= '0;
            cnt_q   <= '0;
            stop_q  <= 1'b0;
        end else if (!busy_q) begin
            stop_q <= 1'b0;
            if (start) begin
                busy_q  <= 1'b1;
                phase_q <= PH_GATE_ON;
                pair_q  <= '0;
                cnt_q   <= '0;
            end
        end else if (phase_end) begin
            cnt_q <= '0;
            if (halt) begin
                busy_q  <= 1'b0;
                phase_q <= PH_GATE_ON;
                pair_q  <= '0;
                stop_q  <= 1'b0;
            end else if (phase_q == PH_GATE_OFF) begin
                phase_q <= PH_GATE_ON;
                pair_q  <= (pair_q == LAST_PAIR) ? '0 : pair_q + PAIR_W'(1);
                stop_q  <= stop_q | stop;
            end else begin
                phase_q <= phase_t'(phase_q + 3'd1);
                stop_q  <= stop_q | stop;
            end
        end else begin
            cnt_q  <= cnt_q + DUR_W'(1);
            stop_q <= stop_q | stop;
        end
    end

    assign busy       = busy_q;
    assign phase      = phase_q;
    assign pair       = pair_q;
    assign frame_done = frame_end;

    // R2
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && (phase_q != $past(phase_q))) |->
        ((32'(phase_q) == 32'($past(phase_q)) + 1) ||
         ((phase_q == PH_GATE_ON) && ($past(phase_q) == PH_GATE_OFF))));

    // R6
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && (pair_q != $past(pair_q))) |->
        ((pair_q == $past(pair_q) + PAIR_W'(1)) || (pair_q == '0)));

    // R7
    idle_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !continuous) |=> !busy_q);

    // R8
    stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_end && stop) |=> !busy_q);

endmodule

// File: rtl/rrs_row_decoder.sv
// Row decoder: turns the active pair and phase into per-row gate and clear
// enables and the two sample strobes. Assumes ROWS_PER_STEP rows per pair.
module rrs_row_decoder
    import rrs_pkg::*;
#(
    parameter int unsigned NUM_PAIRS     = 64,
    parameter int unsigned ROWS_PER_STEP = 2,
    localparam int unsigned NUM_ROWS     = NUM_PAIRS * ROWS_PER_STEP,
    localparam int unsigned PAIR_W       = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                busy,
    input  phase_t              phase,
    input  logic [PAIR_W-1:0]   pair,
    output logic [NUM_ROWS-1:0] gate_row,
    output logic [NUM_ROWS-1:0] clear_row,
    output logic                sample1,
    output logic                sample2
);

    logic gate_on;
    logic clear_on;

    // Phase-level enables shared by every row
    always_comb begin
        gate_on  = busy && (phase != PH_GATE_OFF);
        clear_on = busy && (phase == PH_CLEAR);
        sample1  = busy && (phase == PH_SAMPLE1);
        sample2  = busy && (phase == PH_SAMPLE2);
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic hit;
        // Select this pair when it is the active one
        always_comb hit = (pair == PAIR_W'(p));
        for (genvar r = 0; r < ROWS_PER_STEP; r++) begin : g_row
            assign gate_row[p*ROWS_PER_STEP + r]  = hit && gate_on;
            assign clear_row[p*ROWS_PER_STEP + r] = hit && clear_on;
        end
    end

endmodule

// File: rtl/row_readout_seq.sv
// Row readout sequencer top: timing table, phase controller and row decoder.
// Assumes NUM_ROWS is a multiple of ROWS_PER_STEP. Outputs are decoded
// combinationally from registered state, so they change one clock after
// the controlling edge.
module row_readout_seq
    import rrs_pkg::*;
#(
    parameter int unsigned NUM_ROWS      = 128,
    parameter int unsigned ROWS_PER_STEP = 2,
    parameter int unsigned DUR_W         = 4,
    localparam int unsigned NUM_PAIRS    = NUM_ROWS / ROWS_PER_STEP,
    localparam int unsigned PAIR_W       = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                stop,
    input  logic                continuous,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_idx,
    input  logic [DUR_W-1:0]    cfg_val,
    output logic [NUM_ROWS-1:0] gate_row,
    output logic [NUM_ROWS-1:0] clear_row,
    output logic                sample1,
    output logic                sample2,
    output logic [PAIR_W-1:0]   row_pair,
    output logic                frame_done,
    output logic                busy
);

    phase_t            phase;
    logic [DUR_W-1:0]  rd_dur;
    logic [PAIR_W-1:0] pair;

    rrs_timing_table #(.DUR_W(DUR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_val  (cfg_val),
        .rd_phase (phase),
        .rd_dur   (rd_dur)
    );

    rrs_phase_ctrl #(.NUM_PAIRS(NUM_PAIRS), .DUR_W(DUR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .continuous (continuous),
        .rd_dur     (rd_dur),
        .busy       (busy),
        .phase      (phase),
        .pair       (pair),
        .frame_done (frame_done)
    );

    rrs_row_decoder #(.NUM_PAIRS(NUM_PAIRS), .ROWS_PER_STEP(ROWS_PER_STEP)) u_dec (
        .busy      (busy),
        .phase     (phase),
        .pair      (pair),
        .gate_row  (gate_row),
        .clear_row (clear_row),
        .sample1   (sample1),
        .sample2   (sample2)
    );

    assign row_pair = pair;

    // R4
    clr_sample_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clear_row) |-> (!sample1 && !sample2));

    // R4
    sample_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample1 || sample2) |-> (|gate_row));

    // R3
    gate_pair_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gate_row) |-> ($countones(gate_row) == ROWS_PER_STEP));

    // R3
    clear_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clear_row) |-> (clear_row == gate_row));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((gate_row == '0) && (clear_row == '0) && !frame_done));

endmodule

// File: tb/test_row_readout_seq.sv
module test_row_readout_seq;

    localparam int NR  = 128;
    localparam int RPS = 2;
    localparam int DW  = 4;
    localparam int NP  = NR / RPS;
    localparam int PW  = $clog2(NP);

    // Vectors: durations for gate-on, sample1, clear, sample2, gate-off; continuous
    localparam int NVEC = 4;
    localparam int VEC [NVEC][6] = '{
        '{1, 1, 1, 1, 1, 0},
        '{2, 3, 1, 4, 2, 0},
        '{0, 2, 0, 1, 3, 1},
        '{15, 1, 7, 2, 1, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic          continuous = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [DW-1:0] cfg_val = '0;
    logic [NR-1:0] gate_row;
    logic [NR-1:0] clear_row;
    logic          sample1;
    logic          sample2;
    logic [PW-1:0] row_pair;
    logic          frame_done;
    logic          busy;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    row_readout_seq #(.NUM_ROWS(NR), .ROWS_PER_STEP(RPS), .DUR_W(DW)) i_row_readout_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .continuous(continuous),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
        .gate_row(gate_row), .clear_row(clear_row), .sample1(sample1), .sample2(sample2),
        .row_pair(row_pair), .frame_done(frame_done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input int idx, input int val);
        cfg_we  = 1'b1;
        cfg_idx = 3'(idx);
        cfg_val = DW'(val);
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    function automatic logic [NR-1:0] pair_rows(input int p);
        logic [NR-1:0] v = '0;
        for (int r = 0; r < RPS; r++) v[p*RPS + r] = 1'b1;
        return v;
    endfunction

    // Run one frame against a model built from the durations; stray start at t=7.
    task automatic run_frame(input int a0, input int a1, input int a2, input int a3,
                             input int a4, input bit cont, input string tag);
        int dd[5];
        int s;
        int len;
        int seq_err = 0;
        int fd_err = 0;
        int first_bad = -1;
        dd[0] = a0; dd[1] = a1; dd[2] = a2; dd[3] = a3; dd[4] = a4;
        s = 0;
        for (int i = 0; i < 5; i++) begin
            if (dd[i] < 1) dd[i] = 1;
            s += dd[i];
        end
        len = NP * s;
        continuous = cont;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < len; t++) begin
            int p;
            int off;
            int ph;
            logic [NR-1:0] eg;
            logic [NR-1:0] ec;
            p = t / s;
            off = t % s;
            ph = 0;
            while (off >= dd[ph]) begin
                off -= dd[ph];
                ph++;
            end
            eg = (ph != 4) ? pair_rows(p) : '0;
            ec = (ph == 2) ? pair_rows(p) : '0;
            if (gate_row !== eg || clear_row !== ec || sample1 !== (ph == 1) ||
                sample2 !== (ph == 3) || row_pair !== PW'(p) || busy !== 1'b1) begin
                seq_err++;
                if (first_bad < 0) first_bad = t;
            end
            if (frame_done !== (t == len - 1)) fd_err++;
            start = (t == 7);
            @(negedge clk);
        end
        start = 1'b0;
        // R2 R3 R4 R6 R9: every cycle matches the model despite the stray start
        check(seq_err == 0, "R2/R3/R4/R6/R9", {tag, " sequence mismatches (first cycle)"},
              first_bad, -1);
        // R6: single frame_done in final cycle
        check(fd_err == 0, "R6", {tag, " frame_done misplacements"}, fd_err, 0);
        // R7: wrap or idle right after the frame
        check(busy === cont, "R7", {tag, " busy after frame"}, busy, cont);
        check(gate_row === (cont ? pair_rows(0) : '0), "R7", {tag, " gate rows after frame"},
              longint'(gate_row[63:0]), cont ? 3 : 0);
        if (cont) begin
            // R8: stop during pair 0 of the next frame; idle after that pair
            stop = 1'b1;
            @(negedge clk);
            stop = 1'b0;
            repeat (s - 2) @(negedge clk);
            check(busy === 1'b1, "R8", {tag, " busy in last cycle of stopped pair"}, busy, 1);
            @(negedge clk);
            check(busy === 1'b0, "R8", {tag, " idle after stopped pair"}, busy, 0);
            check(gate_row === '0, "R8", {tag, " gates off after stop"},
                  longint'(gate_row[63:0]), 0);
        end
        continuous = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && gate_row === '0 && clear_row === '0 && !sample1 &&
              !sample2 && !frame_done, "R1", "outputs during reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && gate_row === '0, "R1", "idle after reset", busy, 0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            for (int i = 0; i < 5; i++) write_cfg(i, VEC[v][i]);
            run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
                      VEC[v][5] != 0, $sformatf("vec%0d", v));
        end

        // R5: indices 5..7 leave the table untouched
        write_cfg(5, 3);
        write_cfg(7, 9);
        write_cfg(6, 0);
        run_frame(15, 1, 7, 2, 1, 1'b0, "r5_unused_idx");

        // R1: reset in mid-run forces idle
        continuous = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        continuous = 1'b0;
        check(busy === 1'b0 && gate_row === '0 && clear_row === '0, "R1",
              "idle after mid-run reset", busy, 0);

        // R5: stray stop while idle, then a frame with the reset table (all 1)
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        run_frame(1, 1, 1, 1, 1, 1'b0, "r5_reset_table");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule